// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a stereo audio stream carried on three wires (a bit clock, a frame clock and a data line) and turns it into parallel left and right samples with a one-cycle valid strobe. All three wires are sampled in the local system clock domain. A rising edge of the bit clock marks one data bit. Because of this, the bit clock may stop between bits, or arrive in bursts, without changing the result. The frame clock level, and its changes as seen at the bit-clock edges, set the channel and the word boundaries.

Two control fields choose the framing and the word length. There are four framings. In the standard inter-IC mode the MSB is delayed by one bit. In left-aligned mode the MSB comes at once. In right-aligned mode the last bit of the word sits at the end of the half-frame. In pulse (DSP) mode one short frame pulse starts a left word followed directly by a right word. The word length is 16, 20 or 24 bits. Words arrive MSB first in two's complement and are placed in the top bits of 24-bit outputs, with the low bits zero.

The framing state machine has four states. HUNT waits for a frame start. SKIP drops the one bit that comes before the MSB. SHIFT collects bits. DRAIN ignores bits once the word is full. Its transitions are:
- start: any state to SHIFT in left-aligned mode, or to SKIP in the standard and pulse modes, on a frame start.
- skip: SKIP to SHIFT on the next bit.
- full: SHIFT to DRAIN when the word is complete.
- switch: SHIFT to SHIFT in pulse mode, when the left word is done and collection moves on to the right word.
- lock: HUNT to SHIFT in right-aligned mode.
- restart: any state to HUNT when the configuration changes.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is applied and after its release, `valid_o` is low and both sample outputs are zero until a frame has been received.
- R2: With `fmt_i`=00 (standard), a low frame clock marks the left channel. The MSB is the second bit sampled after a frame-clock level change.
- R3: With `fmt_i`=11 (left-aligned), a high frame clock marks the left channel. The MSB is the first bit sampled after a frame-clock level change.
- R4: With `fmt_i`=01 (right-aligned), the word is made of the last N bits sampled before a frame-clock level change. A high level in the half-frame just ended marks the left channel.
- R5: With `fmt_i`=10 (pulse), a low-to-high frame-clock change starts a pair. The left MSB is the next bit, and the right word follows the left word directly. High-to-low changes are ignored.
- R6: `wsel_i`=00 selects N=24, 01 selects 20, and 10 or 11 select 16. The word fills output bits 23 down to 24-N, and the bits below are zero.
- R7: Bits that arrive after a word is complete, and before the next frame start, have no effect on the outputs.
- R8: A frame start that arrives before N bits have been received ends the current word. The bits already received keep their positions, and the rest are zero.
- R9: `valid_o` pulses for one cycle after a right word completes, provided a left word was captured before it. Between pulses the outputs hold their values. A right word with no left word before it produces no pulse.
- R10: Pauses of any length in the bit clock between bits do not change the received samples.
- R11: A change of `fmt_i` or `wsel_i` drops any pending left word and waits for the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_i | input | 2 | Framing select (00 standard, 01 right-aligned, 10 pulse, 11 left-aligned) |
| wsel_i | input | 2 | Word length select (00 = 24, 01 = 20, 1x = 16) |
| bclk_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| fclk_i | input | 1 | Frame clock |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |

## Verification
The hardest situation to reach is a left word that is still waiting for its right partner at the moment the configuration changes. The stimulus builds it on purpose. It sends a complete left half-frame and then stops the bit clock. It then changes the word length, and the next few bits make a right word that would pair with the stale left word if that word were not dropped. Short half-frames force words to end early in three framings. A burst pattern stretches selected bit periods, so that pausing is tested in every framing.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_DSP = 2'b10,
        FMT_LJ  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_SKIP,
        ST_SHIFT,
        ST_DRAIN
    } rx_state_e;

    function automatic int word_bits(input logic [1:0] code);
        int n;
        unique case (code)
            2'b00:   n = 24;
            2'b01:   n = 20;
            default: n = 16;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/sarx_input_sync.sv
module sarx_input_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fclk_i,
    input  logic sdata_i,
    output logic bit_ev_o,
    output logic bit_o,
    output logic frm_lvl_o
);

    logic [STAGES-1:0] bclk_sr;
    logic [STAGES-1:0] fclk_sr;
    logic [STAGES-1:0] data_sr;
    logic              bclk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_sr   <= '0;
            fclk_sr   <= '0;
            data_sr   <= '0;
            bclk_last <= 1'b0;
        end else begin
            bclk_sr   <= {bclk_sr[STAGES-2:0], bclk_i};
            fclk_sr   <= {fclk_sr[STAGES-2:0], fclk_i};
            data_sr   <= {data_sr[STAGES-2:0], sdata_i};
            bclk_last <= bclk_sr[STAGES-1];
        end
    end

    assign bit_ev_o  = bclk_sr[STAGES-1] & ~bclk_last;
    assign bit_o     = data_sr[STAGES-1];
    assign frm_lvl_o = fclk_sr[STAGES-1];

endmodule

// File: rtl/sarx_framer.sv
module sarx_framer
    import sarx_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   fmt_i,
    input  logic [1:0]   wsel_i,
    input  logic         bit_ev_i,
    input  logic         bit_i,
    input  logic         frm_lvl_i,
    output logic         cmt_o,
    output logic         cmt_left_o,
    output logic [W-1:0] word_o,
    output logic         restart_o
);

    localparam int CW = $clog2(W + 1);
    localparam int IW = $clog2(W);

    fmt_e            fmt;
    rx_state_e       state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d, nbits;
    logic [IW-1:0]   wr_idx;
    logic [W-1:0]    acc_q, acc_d, rj_q, rj_d, word_q, word_d;
    logic            chl_q, chl_d;
    logic            prev_q, prev_d, primed_q, primed_d;
    logic            cmt_q, cmt_d, cmt_left_q, cmt_left_d;
    logic [3:0]      cfg_q;
    logic            cfg_chg, restart_q;
    logic            lvl_chg, word_start;

    assign fmt        = fmt_e'(fmt_i);
    assign nbits      = CW'(word_bits(wsel_i));
    assign wr_idx     = IW'(W - 1 - int'(cnt_q));
    assign cfg_chg    = ({fmt_i, wsel_i} != cfg_q);
    assign lvl_chg    = primed_q & (frm_lvl_i ^ prev_q);
    assign word_start = (fmt == FMT_DSP) ? (lvl_chg & frm_lvl_i) : lvl_chg;

    // next-state and datapath decisions
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        acc_d      = acc_q;
        rj_d       = rj_q;
        chl_d      = chl_q;
        prev_d     = prev_q;
        primed_d   = primed_q;
        cmt_d      = 1'b0;
        cmt_left_d = cmt_left_q;
        word_d     = word_q;
        if (cfg_chg) begin
            state_d = ST_HUNT;
            cnt_d   = '0;
        end else if (bit_ev_i) begin
            prev_d   = frm_lvl_i;
            primed_d = 1'b1;
            rj_d     = {rj_q[W-2:0], bit_i};
            if (fmt == FMT_RJ) begin
                if (lvl_chg) begin
                    if (state_q == ST_SHIFT) begin
                        cmt_d      = 1'b1;
                        cmt_left_d = prev_q;
                        word_d     = rj_q << (CW'(W) - nbits);
                    end
                    state_d = ST_SHIFT;
                end
            end else if (word_start) begin
                if (state_q == ST_SHIFT && cnt_q != '0) begin
                    cmt_d      = 1'b1;
                    cmt_left_d = chl_q;
                    word_d     = acc_q;
                end
                acc_d = '0;
                cnt_d = '0;
                unique case (fmt)
                    FMT_LJ:  chl_d = frm_lvl_i;
                    FMT_I2S: chl_d = ~frm_lvl_i;
                    default: chl_d = 1'b1;
                endcase
                if (fmt == FMT_LJ) begin
                    acc_d[W-1] = bit_i;
                    cnt_d      = CW'(1);
                    state_d    = ST_SHIFT;
                end else begin
                    state_d = ST_SKIP;
                end
            end else begin
                unique case (state_q)
                    ST_SKIP: begin
                        acc_d      = '0;
                        acc_d[W-1] = bit_i;
                        cnt_d      = CW'(1);
                        state_d    = ST_SHIFT;
                    end
                    ST_SHIFT: begin
                        acc_d[wr_idx] = bit_i;
                        if (cnt_q + CW'(1) == nbits) begin
                            cmt_d      = 1'b1;
                            cmt_left_d = chl_q;
                            word_d     = acc_d;
                            if (fmt == FMT_DSP && chl_q) begin
                                chl_d = 1'b0;
                                cnt_d = '0;
                                acc_d = '0;
                            end else begin
                                state_d = ST_DRAIN;
                            end
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            acc_q      <= '0;
            rj_q       <= '0;
            chl_q      <= 1'b0;
            prev_q     <= 1'b0;
            primed_q   <= 1'b0;
            cmt_q      <= 1'b0;
            cmt_left_q <= 1'b0;
            word_q     <= '0;
            cfg_q      <= '0;
            restart_q  <= 1'b0;
        end else begin
            cnt_q      <= cnt_d;
            acc_q      <= acc_d;
            rj_q       <= rj_d;
            chl_q      <= chl_d;
            prev_q     <= prev_d;
            primed_q   <= primed_d;
            cmt_q      <= cmt_d;
            cmt_left_q <= cmt_left_d;
            word_q     <= word_d;
            cfg_q      <= {fmt_i, wsel_i};
            restart_q  <= cfg_chg;
        end
    end

    assign cmt_o      = cmt_q;
    assign cmt_left_o = cmt_left_q;
    assign word_o     = word_q;
    assign restart_o  = restart_q;

endmodule

// File: rtl/sarx_pairer.sv
module sarx_pairer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmt_i,
    input  logic         cmt_left_i,
    input  logic [W-1:0] word_i,
    input  logic         restart_i,
    output logic [W-1:0] left_o,
    output logic [W-1:0] right_o,
    output logic         valid_o
);

    logic [W-1:0] hold_q;
    logic         have_left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            have_left_q <= 1'b0;
            left_o      <= '0;
            right_o     <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (restart_i) begin
                have_left_q <= 1'b0;
            end else if (cmt_i) begin
                if (cmt_left_i) begin
                    hold_q      <= word_i;
                    have_left_q <= 1'b1;
                end else if (have_left_q) begin
                    left_o      <= hold_q;
                    right_o     <= word_i;
                    valid_o     <= 1'b1;
                    have_left_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int OUT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic [1:0]       wsel_i,
    input  logic             bclk_i,
    input  logic             fclk_i,
    input  logic             sdata_i,
    output logic [OUT_W-1:0] left_o,
    output logic [OUT_W-1:0] right_o,
    output logic             valid_o
);

    logic             bit_ev_w, bit_w, frm_lvl_w;
    logic             cmt_w, cmt_left_w, restart_w;
    logic [OUT_W-1:0] word_w;

    sarx_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fclk_i    (fclk_i),
        .sdata_i   (sdata_i),
        .bit_ev_o  (bit_ev_w),
        .bit_o     (bit_w),
        .frm_lvl_o (frm_lvl_w)
    );

    sarx_framer #(.W(OUT_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_i      (fmt_i),
        .wsel_i     (wsel_i),
        .bit_ev_i   (bit_ev_w),
        .bit_i      (bit_w),
        .frm_lvl_i  (frm_lvl_w),
        .cmt_o      (cmt_w),
        .cmt_left_o (cmt_left_w),
        .word_o     (word_w),
        .restart_o  (restart_w)
    );

    sarx_pairer #(.W(OUT_W)) u_pairer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmt_i      (cmt_w),
        .cmt_left_i (cmt_left_w),
        .word_i     (word_w),
        .restart_i  (restart_w),
        .left_o     (left_o),
        .right_o    (right_o),
        .valid_o    (valid_o)
    );

endmodule

// File: rtl/serial_audio_rx_chk.sv
module serial_audio_rx_chk #(
    parameter int W = 24
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   wsel,
    input logic         cmt,
    input logic         cmt_left,
    input logic         valid,
    input logic [W-1:0] left,
    input logic [W-1:0] right
);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid && left == '0 && right == '0)); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(left) && $stable(right))); // R9

    AST_PAIR_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(cmt && !cmt_left)); // R9

    AST_LOW_ZERO_16: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wsel[1] && $past(wsel[1]) && $past(wsel[1], 2))
        |-> (left[W-17:0] == '0 && right[W-17:0] == '0)); // R6

    AST_LOW_ZERO_20: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wsel == 2'b01 && $past(wsel) == 2'b01 && $past(wsel, 2) == 2'b01)
        |-> (left[W-21:0] == '0 && right[W-21:0] == '0)); // R6

endmodule

bind serial_audio_rx serial_audio_rx_chk #(.W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wsel     (wsel_i),
    .cmt      (cmt_w),
    .cmt_left (cmt_left_w),
    .valid    (valid_o),
    .left     (left_o),
    .right    (right_o)
);

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wsel = 2'b00;
    logic        bclk = 1'b0;
    logic        fclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int          n_chk = 0;
    int          n_bad = 0;
    int          cap_n = 0;
    int          dbl = 0;
    logic        v_last = 1'b0;
    logic [23:0] cap_l [32];
    logic [23:0] cap_r [32];
    logic [23:0] exp_l [8];
    logic [23:0] exp_r [8];
    logic [31:0] lcg = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_audio_rx u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .fmt_i   (fmt),
        .wsel_i  (wsel),
        .bclk_i  (bclk),
        .fclk_i  (fclk),
        .sdata_i (sdata),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (cap_n < 32) begin
                cap_l[cap_n] = left_o;
                cap_r[cap_n] = right_o;
            end
            cap_n++;
            if (v_last) dbl++;
        end
        v_last = valid_o;
    end

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [23:0] topk(input logic [23:0] v, input int k);
        if (k <= 0) return 24'h0;
        return v & ~(24'hFF_FFFF >> k);
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [23:0] next_val();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return {lcg[30:29], 1'b1, lcg[28:8]};
    endfunction

    task automatic send_bit(input logic lvl, input logic d, input int gap);
        @(negedge clk);
        fclk  = lvl;
        sdata = d;
        repeat (HB) @(negedge clk);
        bclk = 1'b1;
        repeat (HB) @(negedge clk);
        bclk = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    function automatic logic junk(input int i);
        return logic'(((i >> 0) ^ (i >> 2)) & 1);
    endfunction

    task automatic send_frame(input logic [1:0] f, input int nb, input int half,
                              input logic [23:0] lv, input logic [23:0] rv, input bit burst);
        if (f == 2'b10) begin
            for (int i = 0; i < 2 * half; i++) begin
                logic d;
                if (i >= 1 && i <= nb)          d = lv[24 - i];
                else if (i > nb && i <= 2 * nb) d = rv[24 - (i - nb)];
                else                            d = junk(i);
                send_bit(i == 0, d, (burst && (i % 5 == 2)) ? 9 : 0);
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] v;
                logic        lvl;
                v   = (h == 0) ? lv : rv;
                lvl = (f == 2'b00) ? logic'(h) : ~logic'(h);
                for (int i = 0; i < half; i++) begin
                    int   pos;
                    logic d;
                    if (f == 2'b11)      pos = i;
                    else if (f == 2'b00) pos = i - 1;
                    else                 pos = i - (half - nb);
                    d = (pos >= 0 && pos < nb) ? v[23 - pos] : junk(i + h);
                    send_bit(lvl, d, (burst && (i % 5 == 2)) ? 9 : 0);
                end
            end
        end
    endtask

    task automatic run_cfg(input logic [1:0] f, input logic [1:0] w, input int half,
                           input bit burst, input int nfr, input string tag);
        int nb, kl, kr, idx;
        @(negedge clk);
        fmt  = f;
        wsel = w;
        repeat (4) @(negedge clk);
        cap_n = 0;
        nb = (w == 2'b00) ? 24 : (w == 2'b01) ? 20 : 16;
        if (f == 2'b11)      begin kl = imin(nb, half);     kr = kl; end
        else if (f == 2'b00) begin kl = imin(nb, half - 1); kr = kl; end
        else if (f == 2'b01) begin kl = nb;                 kr = nb; end
        else begin kl = imin(nb, 2 * half - 1); kr = imin(nb, 2 * half - 1 - nb); end
        for (int i = 0; i < 2; i++) send_bit(f == 2'b00, 1'b0, 0);
        send_frame(f, nb, half, 24'h0, 24'h0, burst);
        for (int k = 0; k < nfr; k++) begin
            exp_l[k] = next_val();
            exp_r[k] = next_val();
            send_frame(f, nb, half, exp_l[k], exp_r[k], burst);
        end
        send_frame(f, nb, half, 24'h0, 24'h0, burst);
        repeat (20) @(negedge clk);
        idx = 0;
        while (idx < cap_n && idx < 32 && cap_l[idx] == 24'h0 && cap_r[idx] == 24'h0) idx++;
        for (int k = 0; k < nfr; k++) begin
            logic [23:0] el, er, al, ar;
            el = topk(exp_l[k], kl);
            er = topk(exp_r[k], kr);
            if (idx + k < cap_n && idx + k < 32) begin
                al = cap_l[idx + k];
                ar = cap_r[idx + k];
            end else begin
                al = 24'h0;
                ar = 24'h0;
            end
            chk(al == el && ar == er, $sformatf("%s fmt=%0d wsel=%0d frame %0d", tag, f, w, k),
                {al, ar}, {el, er});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] xv;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk(valid_o == 1'b0, "R1 valid during reset", {47'h0, valid_o}, 48'h0);
        chk(left_o == 24'h0 && right_o == 24'h0, "R1 outputs during reset", {left_o, right_o}, 48'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(valid_o == 1'b0 && left_o == 24'h0 && right_o == 24'h0, "R1 outputs after reset",
            {left_o, right_o}, 48'h0);

        // sweep of every framing and width code, with bits past the word end (R7)
        for (int f = 0; f < 4; f++) begin
            for (int w = 0; w < 4; w++) begin
                string tag;
                unique case (f)
                    0: tag = "R2 R6 R7 R9";
                    1: tag = "R4 R6 R7 R9";
                    2: tag = "R5 R6 R7 R9";
                    default: tag = "R3 R6 R7 R9";
                endcase
                run_cfg(2'(f), 2'(w), 32, 1'b0, 3, tag);
            end
        end

        // R8: frame start arriving before the word is full
        run_cfg(2'b11, 2'b00, 16, 1'b0, 3, "R8 R3 early edge");
        run_cfg(2'b00, 2'b00, 16, 1'b0, 3, "R8 R2 early edge");
        run_cfg(2'b10, 2'b00, 20, 1'b0, 3, "R8 R5 early pulse");

        // R10: bursty bit clock in every framing
        run_cfg(2'b11, 2'b01, 32, 1'b1, 2, "R10 R3 burst");
        run_cfg(2'b01, 2'b00, 32, 1'b1, 2, "R10 R4 burst");
        run_cfg(2'b00, 2'b10, 32, 1'b1, 2, "R10 R2 burst");
        run_cfg(2'b10, 2'b01, 32, 1'b1, 2, "R10 R5 burst");

        // R11: pending left word is dropped by a configuration change
        @(negedge clk);
        fmt  = 2'b11;
        wsel = 2'b00;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++) send_bit(1'b0, 1'b0, 0);
        xv = 24'hA5C3_96;
        for (int i = 0; i < 32; i++) send_bit(1'b1, (i < 24) ? xv[23 - i] : 1'b0, 0);
        run_cfg(2'b11, 2'b10, 32, 1'b0, 2, "R11 R3 restart");

        chk(dbl == 0, "R9 valid longer than one cycle", 48'(dbl), 48'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule